// File: doc/BRIEF.md
# Sticky Event Capture Register

This block watches a bank of independent event lines and remembers which of them have gone high since the last clear. Each line has its own one-bit flag that acts as a two-state machine: its next value is its present value ORed with the line, so once a flag is set it holds until the shared reset clears the whole bank. Every line passes through a chain of synchroniser flops before it may touch its flag. A glitch from asynchronous logic upstream therefore cannot set a flag between clock edges.

Software or a neighbouring block reads the bank one bit at a time. It places an index on the select input, and the addressed flag appears on a single read-data output. A summary output ORs all the flags together, so a single wire reports that at least one event has been captured since the last reset. Both outputs are combinational from the registered flags.

Top module: `sticky_capture`

## Requirements
- R1: `rst` is synchronous and active high. After a rising edge at which `rst` is high, every flag is 0, so `any_flag` is 0 and `rd_bit` is 0 for every select value.
- R2: Reset wins over capture. When `rst` is high at an edge, all flags are 0 after that edge even if every `ev_in` line is high and flags were set before.
- R3: Let an `ev_in` bit be held high for at least two clock periods, and call the first rising edge at which it is sampled high the first edge. Its flag still reads 0 after the second edge and reads 1 after the third edge.
- R4: A set flag stays 1 after its input returns low, for as long as `rst` stays low.
- R5: Raising `ev_in[i]` sets flag i only. Every other flag keeps its value.
- R6: `rd_bit` shows flag N when `rd_sel` holds the value N. Flag N is the flag fed by `ev_in[N]`.
- R7: A change on `rd_sel` shows on `rd_bit` without waiting for a clock edge.
- R8: `any_flag` is the OR of the captured flags, not of the raw inputs. It stays 0 while an input is high but not yet captured, and becomes 1 once any flag is set.
- R9: After reset is released, the flags capture again with the R3 latency, and this includes inputs that were already high during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for the synchronisers and flags |
| rst | input | 1 | Synchronous active-high clear of all flags and synchroniser stages |
| ev_in | input | N_LINES (32) | Asynchronous event lines, one per flag |
| rd_sel | input | SEL_W (5) | Index of the flag routed to `rd_bit` |
| rd_bit | output | 1 | Value of the selected flag |
| any_flag | output | 1 | High when at least one flag is set |

## Verification
A single-line sweep raises each of the 32 inputs in turn from a clean reset and then reads back the whole bank at every select value. This separates a wrong bit position in the selector from a flag that sets its neighbours, and checks the capture latency at exactly the second and third edge. Two dense multi-bit patterns are then applied one after the other without a reset, and the read-back must equal the OR of both. This tells sticky accumulation apart from a flag bank that simply follows its inputs. A final pattern holds every input high across reset, which exposes a reset that loses priority or a synchroniser that keeps stale ones.

// File: rtl/sticky_pkg.sv
package sticky_pkg;

   typedef enum logic [0:0] {
      SEL_TREE = 1'b0,
      SEL_FLAT = 1'b1
   } sel_style_e;

   function automatic int sel_width(input int lines);
      return (lines > 1) ? $clog2(lines) : 1;
   endfunction

endpackage

// File: rtl/sticky_sync.sv
module sticky_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);

   if (STAGES < 2) begin : g_bad_stages
      $fatal(1, "sticky_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][WIDTH-1:0] stage_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         stage_q <= '0;
      end else begin
         stage_q[0] <= d_async;
         for (int s = 1; s < STAGES; s++) begin
            stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/sticky_flags.sv
module sticky_flags #(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] set_in,
   output logic [WIDTH-1:0] flag_q
);

   for (genvar b = 0; b < WIDTH; b++) begin : g_flag
      always_ff @(posedge clk) begin
         if (rst) begin
            flag_q[b] <= 1'b0;
         end else begin
            flag_q[b] <= flag_q[b] | set_in[b];
         end
      end
   end

endmodule

// File: rtl/sticky_rdmux.sv
module sticky_rdmux
   import sticky_pkg::*;
#(
   parameter int         WIDTH = 32,
   parameter sel_style_e STYLE = SEL_TREE,
   localparam int        SEL_W = sel_width(WIDTH),
   localparam int        PAD   = 1 << SEL_W
) (
   input  logic [WIDTH-1:0] data_in,
   input  logic [SEL_W-1:0] sel,
   output logic             data_out
);

   logic [PAD-1:0] padded;

   if (PAD > WIDTH) begin : g_pad
      assign padded = {{(PAD-WIDTH){1'b0}}, data_in};
   end else begin : g_nopad
      assign padded = data_in;
   end

   if (STYLE == SEL_FLAT) begin : g_flat
      assign data_out = padded[sel];
   end else begin : g_tree
      for (genvar l = 0; l <= SEL_W; l++) begin : lv
         logic [(PAD >> l)-1:0] v;
         if (l == 0) begin : g_leaf
            assign v = padded;
         end else begin : g_node
            for (genvar j = 0; j < (PAD >> l); j++) begin : g_pair
               assign v[j] = sel[l-1] ? lv[l-1].v[2*j+1] : lv[l-1].v[2*j];
            end
         end
      end
      assign data_out = lv[SEL_W].v[0];
   end

endmodule

// File: rtl/sticky_orsum.sv
module sticky_orsum
   import sticky_pkg::*;
#(
   parameter int  WIDTH  = 32,
   localparam int LEVELS = sel_width(WIDTH),
   localparam int PAD    = 1 << LEVELS
) (
   input  logic [WIDTH-1:0] data_in,
   output logic             any_out
);

   logic [PAD-1:0] padded;

   if (PAD > WIDTH) begin : g_pad
      assign padded = {{(PAD-WIDTH){1'b0}}, data_in};
   end else begin : g_nopad
      assign padded = data_in;
   end

   for (genvar l = 0; l <= LEVELS; l++) begin : lv
      logic [(PAD >> l)-1:0] v;
      if (l == 0) begin : g_leaf
         assign v = padded;
      end else begin : g_node
         for (genvar j = 0; j < (PAD >> l); j++) begin : g_pair
            assign v[j] = lv[l-1].v[2*j] | lv[l-1].v[2*j+1];
         end
      end
   end

   assign any_out = lv[LEVELS].v[0];

endmodule

// File: rtl/sticky_capture.sv
module sticky_capture
   import sticky_pkg::*;
#(
   parameter int         N_LINES     = 32,
   parameter int         SYNC_STAGES = 2,
   parameter sel_style_e READ_STYLE  = SEL_TREE,
   localparam int        SEL_W       = sel_width(N_LINES)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [N_LINES-1:0] ev_in,
   input  logic [SEL_W-1:0]   rd_sel,
   output logic               rd_bit,
   output logic               any_flag
);

   if (N_LINES < 2) begin : g_bad_lines
      $fatal(1, "sticky_capture: N_LINES must be at least 2");
   end

   logic [N_LINES-1:0] ev_sync;
   logic [N_LINES-1:0] flag_q;

   sticky_sync #(
      .WIDTH  (N_LINES),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk     (clk),
      .rst     (rst),
      .d_async (ev_in),
      .q_sync  (ev_sync)
   );

   sticky_flags #(
      .WIDTH (N_LINES)
   ) u_flags (
      .clk    (clk),
      .rst    (rst),
      .set_in (ev_sync),
      .flag_q (flag_q)
   );

   sticky_rdmux #(
      .WIDTH (N_LINES),
      .STYLE (READ_STYLE)
   ) u_rdmux (
      .data_in  (flag_q),
      .sel      (rd_sel),
      .data_out (rd_bit)
   );

   sticky_orsum #(
      .WIDTH (N_LINES)
   ) u_orsum (
      .data_in (flag_q),
      .any_out (any_flag)
   );

endmodule

// File: rtl/sticky_capture_chk.sv
module sticky_capture_chk #(
   parameter int N_LINES = 32,
   parameter int SEL_W   = 5
) (
   input logic               clk,
   input logic               rst,
   input logic [SEL_W-1:0]   rd_sel,
   input logic               rd_bit,
   input logic               any_flag,
   input logic [N_LINES-1:0] flags
);

   logic rst_seen_q;

   always_ff @(posedge clk) begin
      rst_seen_q <= rst;
   end

   always @(negedge clk) begin
      if (rst_seen_q === 1'b1) begin
         AST_RESET_CLEARS: assert (any_flag == 1'b0 && flags == '0) else $error("reset left flags set"); // R1
      end
   end

   AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (rst)
      !rst |=> ((flags & $past(flags)) == $past(flags))) else $error("flag dropped"); // R4

   AST_READ_ROUTE: assert property (@(posedge clk) disable iff (rst)
      (int'(rd_sel) < N_LINES) |-> (rd_bit == flags[rd_sel])) else $error("read route wrong"); // R6

   AST_SUMMARY_OR: assert property (@(posedge clk) disable iff (rst)
      !rst |-> (any_flag == (flags != '0))) else $error("summary mismatch"); // R8

   AST_ANY_HOLDS: assert property (@(posedge clk) disable iff (rst)
      any_flag |=> any_flag) else $error("summary dropped"); // R4

endmodule

bind sticky_capture sticky_capture_chk #(
   .N_LINES (N_LINES),
   .SEL_W   (SEL_W)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .rd_sel   (rd_sel),
   .rd_bit   (rd_bit),
   .any_flag (any_flag),
   .flags    (flag_q)
);

// File: tb/sticky_capture_tb.sv
`timescale 1ns/10ps
module sticky_capture_tb;

   localparam int N = 32;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [N-1:0]  ev_in = '0;
   logic [4:0]    rd_sel = '0;
   logic          rd_bit;
   logic          any_flag;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   sticky_capture u_dut (
      .clk      (clk),
      .rst      (rst),
      .ev_in    (ev_in),
      .rd_sel   (rd_sel),
      .rd_bit   (rd_bit),
      .any_flag (any_flag)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   // R6 R7: each select value read without a clock edge in between
   task automatic read_all(input logic [N-1:0] exp, input string req);
      for (int k = 0; k < N; k++) begin
         rd_sel = k[4:0];
         #0.1;
         chk(req, rd_bit, exp[k]);
      end
   endtask

   task automatic do_reset();
      rst = 1'b1;
      step(2);
      rst = 1'b0;
   endtask

   initial begin
      logic [N-1:0] pa;
      logic [N-1:0] pb;
      @(negedge clk);
      do_reset();
      chk("R1 any after reset", any_flag, 1'b0);
      read_all('0, "R1 bank clear");

      // single-line sweep
      for (int i = 0; i < N; i++) begin
         do_reset();
         ev_in = N'(1) << i;
         rd_sel = i[4:0];
         step(2);
         chk("R3 not yet set at second edge", rd_bit, 1'b0);
         chk("R8 raw input not in summary", any_flag, 1'b0);
         ev_in = '0;
         step(1);
         rd_sel = i[4:0];
         #0.1;
         chk("R3 set at third edge", rd_bit, 1'b1);
         chk("R8 summary set", any_flag, 1'b1);
         read_all(N'(1) << i, "R5 R6 only line set");
         step(4);
         rd_sel = i[4:0];
         #0.1;
         chk("R4 flag held", rd_bit, 1'b1);
      end

      // accumulation of two patterns
      do_reset();
      pa = 32'hA5C3_0F96;
      pb = 32'h0110_8001;
      ev_in = pa;
      step(2);
      ev_in = '0;
      step(1);
      read_all(pa, "R5 pattern A");
      ev_in = pb;
      step(2);
      ev_in = 32'h0;
      step(3);
      read_all(pa | pb, "R4 accumulate A|B");

      // reset priority with all inputs high
      ev_in = '1;
      rst = 1'b1;
      step(1);
      chk("R2 reset beats inputs", any_flag, 1'b0);
      read_all('0, "R2 bank clear under inputs");
      step(1);
      chk("R2 still clear", any_flag, 1'b0);
      rst = 1'b0;
      step(2);
      chk("R9 latency after release", any_flag, 1'b0);
      step(1);
      chk("R9 captured after release", any_flag, 1'b1);
      read_all('1, "R9 all lines captured");
      ev_in = '0;

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #500000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule